// File: doc/BRIEF.md
# 32-bit Integer ALU with Multiply

This block is a purely combinational arithmetic logic unit for a simple integer datapath. Two 32-bit operands and a 4-bit operation code go in, and one 32-bit result comes out. The unit computes every supported operation at the same time and a final selector picks the one that the code asks for. It has no clock, no reset and no stored state.

The operations are add, subtract, three shifts, signed less-than, the three bitwise logic functions, the low word of the product, and the high word of the product for signed and for unsigned operands. A pass-through of operand B lets a decoder place a ready-made upper immediate on the result path. The operation codes are sparse and fixed, because an instruction decoder next to the block produces them directly.

Top module: `rv_alu`

## Requirements
- R1: Code 0 gives opnd_a + opnd_b, wrapped modulo 2^32.
- R2: Code 12 gives opnd_a - opnd_b, wrapped modulo 2^32.
- R3: Code 1 shifts opnd_a left, filling with zeros. The shift amount is opnd_b[4:0], and bits [31:5] of opnd_b have no effect.
- R4: Code 5 shifts opnd_a right, filling with zeros. Code 13 shifts opnd_a right, filling with opnd_a[31]. Both use opnd_b[4:0] as the shift amount.
- R5: Code 2 gives 1 when opnd_a is less than opnd_b as two's-complement numbers, and 0 otherwise. Bits [31:1] of the result are always zero.
- R6: Code 4 gives the bitwise XOR of the operands, code 6 the bitwise OR, and code 7 the bitwise AND.
- R7: Code 8 gives bits [31:0] of the 64-bit product opnd_a * opnd_b.
- R8: Code 9 gives bits [63:32] of the product, with both operands taken as two's-complement numbers.
- R9: Code 11 gives bits [63:32] of the product, with both operands taken as unsigned numbers.
- R10: Code 15 gives opnd_b unchanged.
- R11: Codes 3, 10 and 14 give a result of zero.
- R12: The result depends only on the present inputs. Applying the same inputs again after other inputs gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, which also carries the shift amount |
| result | output | 32 | Selected result |

## Verification
The checker evaluates its immediate assertions only after the combinational network has settled. It assumes that the code and both operands are known, with no X or Z bits, whenever they are observed. The bench changes all three inputs together at one clock edge and holds them steady for a full cycle. Every input it applies is a fully defined value: the codes come from a 0..15 sweep, the operands from a fixed table of corner patterns, and a shift-amount sweep sets the upper bits of opnd_b.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SHL  = 4'd1,
    OP_SLT  = 4'd2,
    OP_XOR  = 4'd4,
    OP_SHR  = 4'd5,
    OP_OR   = 4'd6,
    OP_AND  = 4'd7,
    OP_MULL = 4'd8,
    OP_MULS = 4'd9,
    OP_MULU = 4'd11,
    OP_SUB  = 4'd12,
    OP_SRA  = 4'd13,
    OP_PASS = 4'd15
  } alu_op_e;
endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  logic [WIDTH-1:0] b_eff;

  // one adder serves add, subtract and the signed compare
  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};

  // signs differ: the negative operand is smaller; otherwise the difference sign decides
  assign lt_o = (a_i[WIDTH-1] ^ b_i[WIDTH-1]) ? a_i[WIDTH-1] : sum_o[WIDTH-1];
endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  output logic [WIDTH-1:0]         shl_o,
  output logic [WIDTH-1:0]         shr_o,
  output logic [WIDTH-1:0]         sra_o
);
  assign shl_o = a_i << amt_i;
  assign shr_o = a_i >> amt_i;
  assign sra_o = WIDTH'($signed(a_i) >>> amt_i);
endmodule

// File: rtl/rv_alu_mul.sv
module rv_alu_mul #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] lo_o,
  output logic [WIDTH-1:0] hi_u_o,
  output logic [WIDTH-1:0] hi_s_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0]    prod_u;
  logic [WIDTH-1:0] corr_a;
  logic [WIDTH-1:0] corr_b;

  assign prod_u = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
  assign lo_o   = prod_u[WIDTH-1:0];
  assign hi_u_o = prod_u[PW-1:WIDTH];

  // the signed high word is the unsigned high word minus the sign-weight terms
  assign corr_a = a_i[WIDTH-1] ? b_i : '0;
  assign corr_b = b_i[WIDTH-1] ? a_i : '0;
  assign hi_s_o = hi_u_o - corr_a - corr_b;
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result
);
  localparam int unsigned SHW = $clog2(WIDTH);

  alu_op_e          op;
  logic             sub_en;
  logic [WIDTH-1:0] sum;
  logic             lt;
  logic [WIDTH-1:0] shl, shr, sra;
  logic [WIDTH-1:0] mlo, mhu, mhs;

  assign op     = alu_op_e'(op_sel);
  assign sub_en = (op == OP_SUB) || (op == OP_SLT);

  rv_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i(opnd_a), .b_i(opnd_b), .sub_i(sub_en), .sum_o(sum), .lt_o(lt)
  );

  rv_alu_shift #(.WIDTH(WIDTH)) i_shift (
    .a_i(opnd_a), .amt_i(opnd_b[SHW-1:0]),
    .shl_o(shl), .shr_o(shr), .sra_o(sra)
  );

  rv_alu_mul #(.WIDTH(WIDTH)) i_mul (
    .a_i(opnd_a), .b_i(opnd_b), .lo_o(mlo), .hi_u_o(mhu), .hi_s_o(mhs)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = sum;
      OP_SHL:         result = shl;
      OP_SLT:         result = {{(WIDTH-1){1'b0}}, lt};
      OP_XOR:         result = opnd_a ^ opnd_b;
      OP_SHR:         result = shr;
      OP_OR:          result = opnd_a | opnd_b;
      OP_AND:         result = opnd_a & opnd_b;
      OP_MULL:        result = mlo;
      OP_MULS:        result = mhs;
      OP_MULU:        result = mhu;
      OP_SRA:         result = sra;
      OP_PASS:        result = opnd_b;
      default:        result = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_checker.sv
module rv_alu_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result
);
  always_comb begin
    if (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14)
      a_r11_unused_zero: assert (result == '0) else $error("unused code gave nonzero");
    if (op_sel == 4'd15)
      a_r10_pass_b: assert (result == opnd_b) else $error("pass B mismatch");
    if (op_sel == 4'd2)
      a_r5_slt_bool: assert (result[WIDTH-1:1] == '0) else $error("compare result not boolean");
    if (op_sel == 4'd0)
      a_r1_add_inverse: assert (result - opnd_b == opnd_a) else $error("sum inconsistent");
    if (op_sel == 4'd12)
      a_r2_sub_inverse: assert (result + opnd_b == opnd_a) else $error("difference inconsistent");
    if (op_sel == 4'd1 && opnd_b[4:0] == 5'd0)
      a_r3_shift_zero: assert (result == opnd_a) else $error("zero shift changed value");
    if (op_sel == 4'd11 && (opnd_a == '0 || opnd_b == '0))
      a_r9_mulhu_zero: assert (result == '0) else $error("zero factor gave nonzero high word");
    if (op_sel == 4'd7)
      a_r6_and_subset: assert ((result & ~opnd_a) == '0) else $error("AND set bit absent in A");
  end
endmodule

bind rv_alu rv_alu_checker #(.WIDTH(WIDTH)) i_rv_alu_checker (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
);

// File: tb/test_rv_alu.sv
module test_rv_alu;
  logic        clk;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b, result;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  localparam int LIMIT = 100000;

  rv_alu i_rv_alu (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run exceeded %0d cycles", LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h0000_0002;   3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;   5: return 32'hFFFF_FFFF;
      6: return 32'hFFFF_FFFE;   7: return 32'h1234_5678;
      8: return 32'hDEAD_BEEF;   9: return 32'h0000_001F;
      10: return 32'h0000_0020;  default: return 32'hFFFF_FF03;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";  4'd12: return "R2";  4'd1: return "R3";
      4'd5, 4'd13: return "R4";  4'd2: return "R5";
      4'd4, 4'd6, 4'd7: return "R6";  4'd8: return "R7";
      4'd9: return "R8";  4'd11: return "R9";  4'd15: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] pu;
    longint      sa, sb, ps;
    int          sh;
    sh = int'(b[4:0]);
    pu = {32'd0, a} * {32'd0, b};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ps = sa * sb;
    case (op)
      4'd0:  return a + b;
      4'd12: return a - b;
      4'd1:  return a << sh;
      4'd5:  return a >> sh;
      4'd13: return (a >> sh) | (a[31] ? ~(32'hFFFF_FFFF >> sh) : 32'd0);
      4'd2:  return (sa < sb) ? 32'd1 : 32'd0;
      4'd4:  return a ^ b;
      4'd6:  return a | b;
      4'd7:  return a & b;
      4'd8:  return pu[31:0];
      4'd9:  return ps[63:32];
      4'd11: return pu[63:32];
      4'd15: return b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] exp;
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    exp = model(op, a, b);
    n_cmp = n_cmp + 1;
    if (result !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s op=%0d a=%h b=%h: got %h expected %h", req, op, a, b, result, exp);
    end
  endtask

  initial begin
    op_sel = 4'd0; opnd_a = '0; opnd_b = '0;
    // first sample: all-zero inputs give zero (R1)
    apply_check(4'd0, 32'd0, 32'd0, "R1");
    // full sweep of codes over corner operand pairs (R1..R11)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply_check(4'(op), corner(i), corner(j), req_of(4'(op)));
    // shift amounts with upper B bits set, which must be ignored (R3, R4)
    for (int s = 0; s < 64; s++) begin
      apply_check(4'd1, 32'h8421_F00D, {26'h2AA_AAAA, 6'(s)}, "R3");
      apply_check(4'd5, 32'h8421_F00D, {26'h155_5555, 6'(s)}, "R4");
      apply_check(4'd13, 32'h8421_F00D, {26'h3FF_FFFF, 6'(s)}, "R4");
      apply_check(4'd13, 32'h7421_F00D, {26'h000_0001, 6'(s)}, "R4");
    end
    // same vector after unrelated traffic gives the same result (R12)
    apply_check(4'd9, 32'hDEAD_BEEF, 32'h8000_0001, "R12");
    apply_check(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R12");
    apply_check(4'd9, 32'hDEAD_BEEF, 32'h8000_0001, "R12");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule